// File: doc/BRIEF.md
# Synchronous Up/Down Binary Counter

This block is a small binary counter clocked by one common clock. Two separate direction inputs choose the operation on each rising edge. One input requests counting up and the other requests counting down. When both are high, counting up wins. The block can also hold its value, or take a preset start value in parallel so that counting begins from any state.

The counter is built in toggle form. On an increment, each bit flips when every bit below it is 1. On a decrement, each bit flips when every bit below it is 0. Bit 0 flips on every count step. An active-low clear acts at once, without waiting for a clock edge, and overrides everything else.

Two terminal flags let stages be chained. The carry flag shows that the next upward step will wrap to zero. The borrow flag shows that the next downward step will wrap to all ones.

Top module: `updn_counter`

## Requirements
- R1: While `rstN` is 0, `count` is 0 without waiting for a clock edge, whatever `load`, `countUp` and `countDown` are.
- R2: With `rstN` at 1 and `load` at 1, the next rising edge writes `loadValue` into `count`. The values of `countUp` and `countDown` have no effect on that edge.
- R3: With `load` at 0 and `countUp` at 1, each rising edge adds one to `count` modulo 2^WIDTH, whatever `countDown` is. With WIDTH=4, the value after 4'b1111 is 4'b0000.
- R4: With `load` at 0, `countUp` at 0 and `countDown` at 1, each rising edge subtracts one from `count` modulo 2^WIDTH. With WIDTH=4, the value after 4'b0000 is 4'b1111.
- R5: With `load`, `countUp` and `countDown` all at 0, a rising edge leaves `count` unchanged.
- R6: `carryOut` is a combinational output. It is 1 exactly when `count` is all ones and `countUp` is 1, independent of `load`.
- R7: `borrowOut` is a combinational output. It is 1 exactly when `count` is all zeros, `countDown` is 1 and `countUp` is 0, independent of `load`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous clear, active low |
| load | input | 1 | Parallel preset request, highest synchronous priority |
| loadValue | input | WIDTH | Preset value taken when `load` is high |
| countUp | input | 1 | Increment request; wins over `countDown` |
| countDown | input | 1 | Decrement request, used when `countUp` is low |
| count | output | WIDTH | Current counter value |
| carryOut | output | 1 | All ones while counting up |
| borrowOut | output | 1 | All zeros while counting down |

## Verification
The bench presets every start value and then applies all eight combinations of load, up and down from each one. This covers both wrap points. A design with a broken toggle chain would miss a carry between bit groups, for example on the step from 0111 to 1000. A design with the wrong priority would decrement, or fail to load, when several controls are high at once.

Long runs with both direction inputs high check that up wins over down. A clear raised between clock edges checks that reset does not wait for a clock. The terminal flags are checked against the expected count on every step. Flags left ungated would fire in the wrong direction.

// File: rtl/updn_pkg.sv
package updn_pkg;
  // Strobes from the control decoder to the datapath; at most one is high.
  typedef struct packed {
    logic doLoad;
    logic doInc;
    logic doDec;
  } ctrlStrobes_t;
endpackage

// File: rtl/updn_ctrl.sv
module updn_ctrl
  import updn_pkg::*;
(
  input  logic         load,
  input  logic         countUp,
  input  logic         countDown,
  input  logic         allOnes,
  input  logic         allZeros,
  output ctrlStrobes_t strobes,
  output logic         carryOut,
  output logic         borrowOut
);
  // Fixed priority: preset, then up, then down.
  always_comb begin
    strobes        = '0;
    strobes.doLoad = load;
    strobes.doInc  = !load && countUp;
    strobes.doDec  = !load && !countUp && countDown;
  end

  // Terminal flags are gated by the effective direction only.
  assign carryOut  = allOnes  && countUp;
  assign borrowOut = allZeros && countDown && !countUp;
endmodule

// File: rtl/updn_datapath.sv
module updn_datapath
  import updn_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [WIDTH-1:0] loadValue,
  output logic [WIDTH-1:0] count,
  output logic             allOnes,
  output logic             allZeros
);
  logic [WIDTH-1:0] toggle;
  logic [WIDTH-1:0] nextBits;

  // Toggle enables: each bit flips when all lower bits match the direction.
  always_comb begin
    logic upRun;
    logic dnRun;
    upRun = 1'b1;
    dnRun = 1'b1;
    for (int i = 0; i < WIDTH; i++) begin
      toggle[i] = (strobes.doInc && upRun) || (strobes.doDec && dnRun);
      upRun = upRun && count[i];
      dnRun = dnRun && !count[i];
    end
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign nextBits[b] = strobes.doLoad ? loadValue[b] : (count[b] ^ toggle[b]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) count[b] <= 1'b0;
      else       count[b] <= nextBits[b];
    end
  end

  assign allOnes  = &count;
  assign allZeros = ~|count;
endmodule

// File: rtl/updn_counter.sv
module updn_counter
  import updn_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [WIDTH-1:0] loadValue,
  input  logic             countUp,
  input  logic             countDown,
  output logic [WIDTH-1:0] count,
  output logic             carryOut,
  output logic             borrowOut
);
  ctrlStrobes_t strobes;
  logic allOnes;
  logic allZeros;

  updn_ctrl u_ctrl (
    .load      (load),
    .countUp   (countUp),
    .countDown (countDown),
    .allOnes   (allOnes),
    .allZeros  (allZeros),
    .strobes   (strobes),
    .carryOut  (carryOut),
    .borrowOut (borrowOut)
  );

  updn_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .loadValue (loadValue),
    .count     (count),
    .allOnes   (allOnes),
    .allZeros  (allZeros)
  );
endmodule

// File: rtl/updn_counter_chk.sv
module updn_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             load,
  input logic [WIDTH-1:0] loadValue,
  input logic             countUp,
  input logic             countDown,
  input logic [WIDTH-1:0] count,
  input logic             carryOut,
  input logic             borrowOut
);
  p_clear_r1: assert property (@(posedge clk) !rstN |-> count == '0);

  p_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    load |=> count == $past(loadValue));

  p_inc_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!load && countUp) |=> count == WIDTH'($past(count) + 1'b1));

  p_dec_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!load && !countUp && countDown) |=> count == WIDTH'($past(count) - 1'b1));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!load && !countUp && !countDown) |=> $stable(count));

  p_carry_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (carryOut && !load) |=> count == '0);

  p_borrow_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (borrowOut && !load) |=> count == '1);

  p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(carryOut && borrowOut));
endmodule

bind updn_counter updn_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .load      (load),
  .loadValue (loadValue),
  .countUp   (countUp),
  .countDown (countDown),
  .count     (count),
  .carryOut  (carryOut),
  .borrowOut (borrowOut)
);

// File: tb/updn_counter_tb.sv
`timescale 1ns/1ps
module updn_counter_tb;
  localparam int W = 4;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic load = 1'b0;
  logic [W-1:0] loadValue = '0;
  logic countUp = 1'b0;
  logic countDown = 1'b0;
  logic [W-1:0] count;
  logic carryOut;
  logic borrowOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int expCount = 0;

  always #2.5 clk = ~clk;

  updn_counter #(.WIDTH(W)) u_dut (
    .clk(clk), .rstN(rstN), .load(load), .loadValue(loadValue),
    .countUp(countUp), .countDown(countDown),
    .count(count), .carryOut(carryOut), .borrowOut(borrowOut)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Called just after a falling edge: drive, check flags, then check count next falling edge.
  task automatic step(input bit ld, input int val, input bit up, input bit dn);
    load = ld; loadValue = W'(val); countUp = up; countDown = dn;
    #1;
    check("R6 carry", int'(carryOut), int'(expCount == MAXV && up));
    check("R7 borrow", int'(borrowOut), int'(expCount == 0 && dn && !up));
    if (ld)       expCount = val & MAXV;       // R2
    else if (up)  expCount = (expCount + 1) & MAXV;  // R3
    else if (dn)  expCount = (expCount + MAXV) & MAXV; // R4
    @(negedge clk);
    if (ld)            check("R2 load", int'(count), expCount);
    else if (up)       check("R3 up", int'(count), expCount);
    else if (dn)       check("R4 down", int'(count), expCount);
    else               check("R5 hold", int'(count), expCount);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", int'(count), 0);
    check("R6 carry in reset", int'(carryOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R5 idle after reset", int'(count), 0);

    // Sweep every start value against every control combination.
    for (int s = 0; s <= MAXV; s++) begin
      for (int m = 0; m < 8; m++) begin
        step(1'b1, s, 1'b0, 1'b0);
        step(m[2], MAXV - s, m[1], m[0]);
      end
    end

    // Up wins over down across two full wraps.
    step(1'b1, MAXV - 2, 1'b0, 1'b0);
    for (int k = 0; k < 2 * (MAXV + 1) + 3; k++) step(1'b0, 0, 1'b1, 1'b1);
    // Plain down run across two wraps.
    for (int k = 0; k < 2 * (MAXV + 1) + 3; k++) step(1'b0, 0, 1'b0, 1'b1);
    // Hold run.
    for (int k = 0; k < 5; k++) step(1'b0, 0, 1'b0, 1'b0);

    // R1: clear mid-cycle with load and up active.
    step(1'b1, 9, 1'b0, 1'b0);
    load = 1'b1; loadValue = 4'd5; countUp = 1'b1;
    #1 rstN = 1'b0;
    #0.5 check("R1 async clear", int'(count), 0);
    @(negedge clk);
    check("R1 clear overrides load", int'(count), 0);
    rstN = 1'b1;
    expCount = 0;
    step(1'b0, 0, 1'b0, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule